// File: doc/BRIEF.md
# Auxiliary RAM Access Steering

This block sits between a CPU's external-data port and the chip's external bus. Each external-data access arrives as an address, a read or write strobe and a flag giving the pointer kind: an 8-bit register pointer or a 16-bit data pointer. The block sends the access either to a 256-byte on-chip auxiliary RAM or out to the external bus. A bit in a chip control register selects whether the on-chip RAM is in use at all.

When an access is served on-chip, the external bus sees nothing. Its strobes stay low, and its address and write-data lines keep their previous values. A read takes the same number of cycles whichever path serves it, so the CPU's timing does not change when the RAM is switched on or off.

Top module: `auxram_steer`

## Requirements
- R1: The on-chip RAM holds 256 bytes and is reached only through the access port. A byte written to an on-chip index reads back unchanged, at every index from 0 to 255.
- R2: After reset the on-chip RAM is disabled and every access goes to the external bus. All outputs are 0 during and straight after reset.
- R3: A control write (`ctl_we`=1) loads the enable from bit 4 of `ctl_wdata`: 1 enables the RAM and 0 disables it. The other seven bits have no effect.
- R4: While enabled, an access with `acc_ptr8`=1 (8-bit register pointer) is always served on-chip at index `acc_addr[7:0]`, whatever the value of `acc_addr[15:8]`.
- R5: While enabled, an access with `acc_ptr8`=0 (16-bit data pointer) whose address is above 255 goes to the external bus.
- R6: While enabled, an access with `acc_ptr8`=0 whose address is 0 to 255 is served on-chip.
- R7: An access served on-chip raises no external strobe, and it leaves `ext_addr` and `ext_wdata` unchanged. It raises `int_rd` or `int_wr` in the same cycle as the request.
- R8: Every read returns `rd_data` with `rd_valid`=1 exactly two cycles after the cycle in which `acc_rd` is high, on both paths. On an external read, `ext_rdata` is sampled in the cycle in which `ext_rd` is high.
- R9: An external access shows `ext_rd` or `ext_wr` for one cycle, together with its address (and its write data, for writes), one cycle after the request. `ext_wdata` changes only on external writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data; bit 4 is the enable |
| acc_ptr8 | input | 1 | 1 = 8-bit register pointer access, 0 = 16-bit data pointer access |
| acc_addr | input | 16 | Access address |
| acc_rd | input | 1 | Read request |
| acc_wr | input | 1 | Write request |
| acc_wdata | input | 8 | Write data |
| ext_rdata | input | 8 | External bus read data |
| int_rd | output | 1 | On-chip RAM read strobe |
| int_wr | output | 1 | On-chip RAM write strobe |
| ext_rd | output | 1 | Gated external read strobe |
| ext_wr | output | 1 | Gated external write strobe |
| ext_addr | output | 16 | External bus address, held between external accesses |
| ext_wdata | output | 8 | External bus write data, held between external writes |
| rd_data | output | 8 | Read result |
| rd_valid | output | 1 | Read result valid |

## Verification
The on-chip strobes are due in the request cycle itself. External strobes, address and write data are due one cycle after the request, and read results two cycles after. The driver applies each request at a falling edge and pushes the bus event or the read result it expects into a queue. The monitor samples at every later falling edge and pops an item only when the design raises an external strobe or `rd_valid`, so a result that arrives early or late fails its compare. In every cycle with no external strobe, the monitor also checks that the external address and write data still hold the values from the last external access.

// File: rtl/auxsteer_pkg.sv
package auxsteer_pkg;
  // Bit of the control register that enables the on-chip RAM.
  localparam int unsigned ENABLE_BIT = 4;

  // Decide whether an access lands in the on-chip RAM.
  function automatic logic lands_onchip(input logic en, input logic ptr8, input logic hi_zero);
    return en & (ptr8 | hi_zero);
  endfunction

  // Read return path selector for the pending read.
  typedef enum logic {SRC_BUS = 1'b0, SRC_RAM = 1'b1} rd_src_e;
endpackage

// File: rtl/auxsteer_ctl.sv
module auxsteer_ctl #(
  parameter int unsigned CTL_W = 8,
  parameter int unsigned EN_BIT = auxsteer_pkg::ENABLE_BIT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  output logic             en
);
  always_ff @(posedge clk) begin
    if (!rst_n)  en <= 1'b0;
    else if (we) en <= wdata[EN_BIT];
  end

  // Only the enable bit is kept; the rest of the byte is folded away.
  logic unused_bits;
  assign unused_bits = ^{wdata[CTL_W-1:EN_BIT+1], wdata[EN_BIT-1:0]};
endmodule

// File: rtl/auxsteer_mem.sv
module auxsteer_mem #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned DW    = 8
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    q
);
  localparam int unsigned DEPTH = 1 << IDX_W;
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[idx] <= wdata;
    if (rd_en) q <= cells[idx];
  end
endmodule

// File: rtl/auxsteer_route.sv
module auxsteer_route #(
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 8,
  parameter int unsigned IDX_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          ptr8,
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic          hit,
  output logic          int_rd,
  output logic          int_wr,
  output logic          ext_rd_q,
  output logic          ext_wr_q,
  output logic [AW-1:0] ext_addr_q,
  output logic [DW-1:0] ext_wdata_q
);
  import auxsteer_pkg::*;

  logic hi_zero;
  logic ext_go;
  assign hi_zero = (addr[AW-1:IDX_W] == '0);
  assign hit     = lands_onchip(en, ptr8, hi_zero);
  assign int_rd  = rd & hit;
  assign int_wr  = wr & hit;
  assign ext_go  = (rd | wr) & ~hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_rd_q    <= 1'b0;
      ext_wr_q    <= 1'b0;
      ext_addr_q  <= '0;
      ext_wdata_q <= '0;
    end else begin
      ext_rd_q <= rd & ~hit;
      ext_wr_q <= wr & ~hit;
      if (ext_go)    ext_addr_q  <= addr;
      if (wr & ~hit) ext_wdata_q <= wdata;
    end
  end

  AST_DISABLED_NO_INT: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!int_rd && !int_wr)); // R2
  AST_PTR8_ONCHIP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ptr8 && (rd || wr)) |-> (int_rd || int_wr)); // R4
  AST_HIGH_TO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !ptr8 && !hi_zero && rd) |=> ext_rd_q); // R5
  AST_LOW_ONCHIP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !ptr8 && hi_zero && (rd || wr)) |-> hit); // R6
  AST_SILENT_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && (rd || wr)) |=> (!ext_rd_q && !ext_wr_q && $stable(ext_addr_q) && $stable(ext_wdata_q))); // R7
endmodule

// File: rtl/auxram_steer.sv
module auxram_steer #(
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 8,
  parameter int unsigned CTL_W = 8,
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             acc_ptr8,
  input  logic [AW-1:0]    acc_addr,
  input  logic             acc_rd,
  input  logic             acc_wr,
  input  logic [DW-1:0]    acc_wdata,
  input  logic [DW-1:0]    ext_rdata,
  output logic             int_rd,
  output logic             int_wr,
  output logic             ext_rd,
  output logic             ext_wr,
  output logic [AW-1:0]    ext_addr,
  output logic [DW-1:0]    ext_wdata,
  output logic [DW-1:0]    rd_data,
  output logic             rd_valid
);
  import auxsteer_pkg::*;

  logic          en;
  logic          hit;
  logic [DW-1:0] ram_q;
  logic          pend_rd;
  rd_src_e       pend_src;

  auxsteer_ctl #(.CTL_W(CTL_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata), .en(en)
  );

  auxsteer_route #(.AW(AW), .DW(DW), .IDX_W(IDX_W)) u_route (
    .clk(clk), .rst_n(rst_n), .en(en), .ptr8(acc_ptr8), .addr(acc_addr),
    .rd(acc_rd), .wr(acc_wr), .wdata(acc_wdata), .hit(hit),
    .int_rd(int_rd), .int_wr(int_wr), .ext_rd_q(ext_rd), .ext_wr_q(ext_wr),
    .ext_addr_q(ext_addr), .ext_wdata_q(ext_wdata)
  );

  auxsteer_mem #(.IDX_W(IDX_W), .DW(DW)) u_mem (
    .clk(clk), .wr_en(int_wr), .rd_en(int_rd), .idx(acc_addr[IDX_W-1:0]),
    .wdata(acc_wdata), .q(ram_q)
  );

  // Both paths return read data two edges after the request.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_rd  <= 1'b0;
      pend_src <= SRC_BUS;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      pend_rd  <= acc_rd;
      pend_src <= hit ? SRC_RAM : SRC_BUS;
      rd_valid <= pend_rd;
      if (pend_rd) rd_data <= (pend_src == SRC_RAM) ? ram_q : ext_rdata;
    end
  end

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> ##1 rd_valid); // R8
  AST_BUS_READ_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rd |=> !ext_rd || $past(acc_rd)); // R9
endmodule

// File: tb/auxram_steer_bench.sv
module auxram_steer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic        acc_ptr8 = 1'b0;
  logic [15:0] acc_addr = '0;
  logic        acc_rd = 1'b0;
  logic        acc_wr = 1'b0;
  logic [7:0]  acc_wdata = '0;
  logic [7:0]  ext_rdata;
  logic        int_rd, int_wr, ext_rd, ext_wr, rd_valid;
  logic [15:0] ext_addr;
  logic [7:0]  ext_wdata, rd_data;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] bus_val(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  assign ext_rdata = ext_rd ? bus_val(ext_addr) : 8'h00;

  auxram_steer u_auxram_steer (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .acc_ptr8(acc_ptr8), .acc_addr(acc_addr), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .acc_wdata(acc_wdata), .ext_rdata(ext_rdata), .int_rd(int_rd), .int_wr(int_wr),
    .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  int checks = 0;
  int fails = 0;
  logic        m_en = 1'b0;
  logic [7:0]  m_mem [256];
  logic [24:0] bus_q [$];   // {is_wr, addr, wdata}
  logic [7:0]  rd_q [$];
  logic [15:0] last_addr = '0;
  logic [7:0]  last_wdata = '0;
  logic        mon_on = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ctl_write(input logic [7:0] v);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = v;
    m_en = v[4];
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  // One-cycle access; expected results pushed to the scoreboard.
  task automatic access(input logic p8, input logic [15:0] a, input logic w,
                        input logic [7:0] d, input string req);
    logic onchip;
    onchip = m_en && (p8 || a[15:8] == 8'h00);
    @(negedge clk);
    acc_ptr8 = p8; acc_addr = a; acc_rd = !w; acc_wr = w; acc_wdata = d;
    #0.5;
    check({req, " int strobe"}, {30'd0, int_rd, int_wr}, onchip ? (w ? 32'd1 : 32'd2) : 32'd0);
    if (onchip) begin
      if (w) m_mem[a[7:0]] = d;
      else rd_q.push_back(m_mem[a[7:0]]);
    end else begin
      bus_q.push_back({w, a, w ? d : 8'h00});
      if (!w) rd_q.push_back(bus_val(a));
    end
    @(negedge clk);
    acc_rd = 1'b0; acc_wr = 1'b0;
  endtask

  // Back-to-back accesses without idle cycles.
  task automatic burst_fill;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      acc_ptr8 = i[0]; acc_addr = {i[0] ? 8'hC3 : 8'h00, i[7:0]};
      acc_wr = 1'b1; acc_rd = 1'b0; acc_wdata = i[7:0] ^ 8'hA5;
      m_mem[i[7:0]] = i[7:0] ^ 8'hA5;
    end
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      acc_ptr8 = 1'b0; acc_addr = {8'h00, i[7:0]};
      acc_wr = 1'b0; acc_rd = 1'b1;
      rd_q.push_back(m_mem[i[7:0]]);
    end
    @(negedge clk);
    acc_rd = 1'b0;
  endtask

  // Monitor: pops the scoreboard when the design shows a result.
  always @(negedge clk) begin
    if (mon_on) begin
      if (ext_rd || ext_wr) begin
        if (bus_q.size() == 0) check("R7 unexpected bus strobe", {ext_rd, ext_wr, ext_addr}, 0);
        else begin
          logic [24:0] e;
          e = bus_q.pop_front();
          check("R9 bus strobe kind", {30'd0, ext_rd, ext_wr}, e[24] ? 32'd1 : 32'd2);
          check("R9 bus address", {16'd0, ext_addr}, {16'd0, e[23:8]});
          last_addr = e[23:8];
          if (e[24]) begin
            check("R9 bus write data", {24'd0, ext_wdata}, {24'd0, e[7:0]});
            last_wdata = e[7:0];
          end else
            check("R9 bus write data held", {24'd0, ext_wdata}, {24'd0, last_wdata});
        end
      end else begin
        check("R7 held bus address", {16'd0, ext_addr}, {16'd0, last_addr});
        check("R7 held bus data", {24'd0, ext_wdata}, {24'd0, last_wdata});
      end
      if (rd_valid) begin
        if (rd_q.size() == 0) check("R8 unexpected read result", {24'd0, rd_data}, 32'hFFFF);
        else check("R8 read data", {24'd0, rd_data}, {24'd0, rd_q.pop_front()});
      end
    end
  end

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
      begin
        repeat (3) @(negedge clk);
        check("R2 reset outputs", {int_rd, int_wr, ext_rd, ext_wr, rd_valid, ext_addr, ext_wdata},
              32'd0);
        check("R2 reset rd_data", {24'd0, rd_data}, 32'd0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        // R2: disabled after reset, everything to the bus.
        access(1'b1, 16'h0012, 1'b1, 8'h4E, "R2 ptr8 write");
        access(1'b0, 16'h0034, 1'b0, 8'h00, "R2 dptr read");
        access(1'b1, 16'h0010, 1'b0, 8'h00, "R2 ptr8 read");
        // R3: bit 4 clear with other bits set keeps it disabled.
        ctl_write(8'hEF);
        access(1'b1, 16'h0020, 1'b0, 8'h00, "R3 bit4 clear");
        ctl_write(8'h10);
        // R4: ptr8 ignores the high byte.
        access(1'b1, 16'hAB05, 1'b1, 8'h3C, "R4 ptr8 write high byte");
        access(1'b1, 16'hFF05, 1'b0, 8'h00, "R4 ptr8 read");
        // R6 / R5 boundary.
        access(1'b0, 16'h00FF, 1'b1, 8'h99, "R6 dptr 255 write");
        access(1'b0, 16'h0100, 1'b1, 8'h77, "R5 dptr 256 write");
        access(1'b0, 16'h00FF, 1'b0, 8'h00, "R6 dptr 255 read");
        access(1'b0, 16'h0005, 1'b0, 8'h00, "R6 dptr low read");
        access(1'b0, 16'h1234, 1'b0, 8'h00, "R5 dptr high read");
        access(1'b0, 16'hFFFF, 1'b1, 8'h21, "R5 dptr top write");
        // R1: full-array fill and readback, back to back.
        burst_fill();
        // R3: disabling sends the low address back to the bus.
        ctl_write(8'h00);
        access(1'b0, 16'h0005, 1'b0, 8'h00, "R3 disabled again");
        access(1'b1, 16'h0006, 1'b1, 8'h55, "R3 disabled ptr8 write");
        repeat (6) @(negedge clk);
        check("R8 read queue drained", rd_q.size(), 0);
        check("R9 bus queue drained", bus_q.size(), 0);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule